// File: doc/BRIEF.md
# Three-Level Early/Late Phase Detector

This block is the decision stage of an edge-sampling phase detector in a receiver's clock recovery loop. For each received symbol it is given two sliced data decisions, the one before and the one now, plus a digitized signed edge sample. The edge sample is taken midway between the two data instants. From these it decides whether the recovered clock is ahead of the data (early), behind it (late) or cannot tell. It issues that result as a single-cycle pulse to the downstream loop filter.

A mode pin chooses between two-level operation and three-level operation. In two-level operation each decision is one of two values. In three-level operation the decision levels are −0.5, 0 and +0.5. In three-level mode the level that the edge sample is compared against depends on which two levels the transition spans. Whether "above" means early or late depends on the direction of the transition. The edge threshold magnitude is a writable register. Data slicing, edge sampling and vote accumulation happen outside this block.

Top module: `trilevel_pd`

## Requirements
- R1: After reset `early` and `late` are low and the edge threshold magnitude is 32.
- R2: When `sym_valid` is high at a clock edge, the result for that symbol appears on `early`/`late` after that edge and lasts one cycle. When `sym_valid` is low at an edge, both outputs are low after it.
- R3: `early` and `late` are never high in the same cycle.
- R4: In two-level mode (`mode_tri` = 0) only bit 0 of each decision is used: 1 means +1 and 0 means −1. The edge decision is +1 when `edge_smp` > 0 and −1 otherwise. When the two data decisions are equal, neither output is asserted.
- R5: In two-level mode, with differing data decisions, an edge decision equal to the current decision gives `late`. An edge decision equal to the previous decision gives `early`.
- R6: In three-level mode (`mode_tri` = 1) decisions are coded 00 = −0.5, 01 = 0 and 10 = +0.5, and the edge sample is scaled so that +0.5 is 64. If the two codes are equal, or either code is 11, neither output is asserted.
- R7: In three-level mode the comparison level depends on the levels involved. It is −th for a transition between −0.5 and 0, +th for one between 0 and +0.5, and 0 for a swing between −0.5 and +0.5.
- R8: For a rising transition (current code greater than previous), an edge sample strictly above the comparison level gives `late`. A sample at or below it gives `early`.
- R9: For a falling transition, an edge sample strictly above the comparison level gives `early`. A sample at or below it gives `late`.
- R10: A cycle with `thr_we` high loads `thr_wdata` (unsigned) as th. The new value applies to symbols strobed from the next edge onward. A symbol strobed in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol strobe; the decisions and edge sample are valid |
| mode_tri | input | 1 | 0 = two-level, 1 = three-level |
| prev_dec | input | 2 | Previous data decision |
| curr_dec | input | 2 | Current data decision |
| edge_smp | input | EDGE_W (8) | Signed edge sample |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | EDGE_W-1 (7) | New threshold magnitude |
| early | output | 1 | Clock early pulse |
| late | output | 1 | Clock late pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit edge sample, a reset threshold of 32 and the three-level logic present. With these values the bench reaches the extremes of the sample range directly. These include −128 against a threshold of 127, a threshold of zero, and samples one below, equal to and one above every comparison level. A threshold write in the same cycle as a symbol shows which threshold value that symbol uses.

// File: rtl/trilevel_pd_pkg.sv
package trilevel_pd_pkg;

   typedef enum logic [1:0] {
      LVL_NEG = 2'b00,
      LVL_MID = 2'b01,
      LVL_POS = 2'b10,
      LVL_BAD = 2'b11
   } lvl_code_e;

   typedef struct packed {
      logic early;
      logic late;
   } pd_vote_t;

endpackage

// File: rtl/pd_binary_decide.sv
module pd_binary_decide
   import trilevel_pd_pkg::*;
#(
   parameter int EDGE_W = 8
) (
   input  logic                     prev_bit,
   input  logic                     curr_bit,
   input  logic signed [EDGE_W-1:0] edge_smp,
   output pd_vote_t                 vote
);

   logic edge_bit;

   // positive and nonzero resolves to +1; zero counts as the low side
   assign edge_bit = !edge_smp[EDGE_W-1] && (edge_smp != '0);

   always_comb begin
      vote = '0;
      if (prev_bit != curr_bit) begin
         vote.late  = (edge_bit == curr_bit);
         vote.early = (edge_bit == prev_bit);
      end
   end

endmodule

// File: rtl/pd_ternary_decide.sv
module pd_ternary_decide
   import trilevel_pd_pkg::*;
#(
   parameter int EDGE_W = 8
) (
   input  logic [1:0]               prev_code,
   input  logic [1:0]               curr_code,
   input  logic signed [EDGE_W-1:0] edge_smp,
   input  logic [EDGE_W-2:0]        thr,
   output pd_vote_t                 vote
);

   // one extra bit so that -thr and the sample share a range
   localparam int CW = EDGE_W + 1;

   logic signed [CW-1:0] edge_x;
   logic signed [CW-1:0] thr_pos;
   logic signed [CW-1:0] thr_neg;
   logic signed [CW-1:0] ref_lvl;
   logic                 usable;
   logic                 has_neg;
   logic                 has_pos;
   logic                 rising;
   logic                 above;

   assign edge_x  = {edge_smp[EDGE_W-1], edge_smp};
   assign thr_pos = {2'b00, thr};
   assign thr_neg = -thr_pos;

   assign usable  = (prev_code != LVL_BAD) && (curr_code != LVL_BAD) &&
                    (prev_code != curr_code);
   assign has_neg = (prev_code == LVL_NEG) || (curr_code == LVL_NEG);
   assign has_pos = (prev_code == LVL_POS) || (curr_code == LVL_POS);
   assign rising  = curr_code > prev_code;

   always_comb begin
      if (has_neg && has_pos)
         ref_lvl = '0;
      else if (has_neg)
         ref_lvl = thr_neg;
      else
         ref_lvl = thr_pos;
   end

   // equality falls on the low side
   assign above = edge_x > ref_lvl;

   always_comb begin
      vote = '0;
      if (usable) begin
         vote.late  = rising ? above : !above;
         vote.early = rising ? !above : above;
      end
   end

endmodule

// File: rtl/pd_thr_reg.sv
module pd_thr_reg #(
   parameter int TW      = 7,
   parameter int RST_VAL = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [TW-1:0] wdata,
   output logic [TW-1:0] thr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         thr_q <= TW'(RST_VAL);
      else if (we)
         thr_q <= wdata;
   end

   assert_thr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> thr_q == $past(wdata));

   assert_thr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we && $past(rst_n) |=> $stable(thr_q));

endmodule

// File: rtl/pd_vote_reg.sv
module pd_vote_reg
   import trilevel_pd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     strobe,
   input  pd_vote_t vote_in,
   output logic     early,
   output logic     late
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         early <= 1'b0;
         late  <= 1'b0;
      end else if (strobe) begin
         early <= vote_in.early;
         late  <= vote_in.late;
      end else begin
         early <= 1'b0;
         late  <= 1'b0;
      end
   end

   assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> !early && !late);

   assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(early && late));

endmodule

// File: rtl/trilevel_pd.sv
module trilevel_pd
   import trilevel_pd_pkg::*;
#(
   parameter int EDGE_W     = 8,
   parameter int TH_RESET   = 32,
   parameter bit TERNARY_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sym_valid,
   input  logic                     mode_tri,
   input  logic [1:0]               prev_dec,
   input  logic [1:0]               curr_dec,
   input  logic signed [EDGE_W-1:0] edge_smp,
   input  logic                     thr_we,
   input  logic [EDGE_W-2:0]        thr_wdata,
   output logic                     early,
   output logic                     late
);

   localparam int TW     = EDGE_W - 1;
   localparam int TH_MAX = (1 << TW) - 1;

   if (EDGE_W < 4 || EDGE_W > 16) begin : g_bad_width
      $error("trilevel_pd: EDGE_W must lie in 4..16");
   end
   if (TH_RESET < 0 || TH_RESET > TH_MAX) begin : g_bad_thr
      $error("trilevel_pd: TH_RESET does not fit in EDGE_W-1 bits");
   end

   logic [TW-1:0] thr_q;
   pd_vote_t      vote_bin;
   pd_vote_t      vote_sel;

   pd_thr_reg #(.TW(TW), .RST_VAL(TH_RESET)) u_thr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (thr_we),
      .wdata (thr_wdata),
      .thr_q (thr_q)
   );

   pd_binary_decide #(.EDGE_W(EDGE_W)) u_bin (
      .prev_bit (prev_dec[0]),
      .curr_bit (curr_dec[0]),
      .edge_smp (edge_smp),
      .vote     (vote_bin)
   );

   if (TERNARY_EN) begin : g_tri
      pd_vote_t vote_tri;

      pd_ternary_decide #(.EDGE_W(EDGE_W)) u_tri (
         .prev_code (prev_dec),
         .curr_code (curr_dec),
         .edge_smp  (edge_smp),
         .thr       (thr_q),
         .vote      (vote_tri)
      );

      assign vote_sel = mode_tri ? vote_tri : vote_bin;

      assert_tri_flat_R6: assert property (@(posedge clk) disable iff (!rst_n)
         sym_valid && mode_tri &&
         (prev_dec == curr_dec || prev_dec == LVL_BAD || curr_dec == LVL_BAD)
         |=> !early && !late);

      assert_tri_swing_R7: assert property (@(posedge clk) disable iff (!rst_n)
         sym_valid && mode_tri && prev_dec == LVL_NEG && curr_dec == LVL_POS
         && edge_smp == '0 |=> early && !late);
   end else begin : g_bin_only
      logic unused_mode;
      assign unused_mode = mode_tri ^ ^thr_q ^ prev_dec[1] ^ curr_dec[1];
      assign vote_sel    = vote_bin;
   end

   pd_vote_reg u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (sym_valid),
      .vote_in (vote_sel),
      .early   (early),
      .late    (late)
   );

   assert_bin_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid && !mode_tri && prev_dec[0] == curr_dec[0] |=> !early && !late);

   assert_bin_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid && !mode_tri && prev_dec[0] != curr_dec[0]
      |=> $countones({early, late}) == 1);

endmodule

// File: tb/trilevel_pd_bench.sv
module trilevel_pd_bench;

   localparam int EW = 8;
   localparam int TW = EW - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 sym_valid = 1'b0;
   logic                 mode_tri = 1'b0;
   logic [1:0]           prev_dec = '0;
   logic [1:0]           curr_dec = '0;
   logic signed [EW-1:0] edge_smp = '0;
   logic                 thr_we = 1'b0;
   logic [TW-1:0]        thr_wdata = '0;
   logic                 early;
   logic                 late;

   int n_chk  = 0;
   int n_fail = 0;
   int thr_m  = 32;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   trilevel_pd u_trilevel_pd (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym_valid (sym_valid),
      .mode_tri  (mode_tri),
      .prev_dec  (prev_dec),
      .curr_dec  (curr_dec),
      .edge_smp  (edge_smp),
      .thr_we    (thr_we),
      .thr_wdata (thr_wdata),
      .early     (early),
      .late      (late)
   );

   // returns {early, late} per the requirements
   function automatic logic [1:0] expect_vote(input logic m, input int p,
                                              input int c, input int e, input int th);
      int  lvl;
      bit  eb;
      bit  above;
      if (!m) begin
         eb = (e > 0);
         if ((p % 2) == (c % 2)) return 2'b00;
         return (eb == bit'(c % 2)) ? 2'b01 : 2'b10;
      end
      if (p == 3 || c == 3 || p == c) return 2'b00;
      if ((p == 0 && c == 2) || (p == 2 && c == 0)) lvl = 0;
      else if (p == 0 || c == 0) lvl = -th;
      else lvl = th;
      above = (e > lvl);
      if (c > p) return above ? 2'b01 : 2'b10;
      return above ? 2'b10 : 2'b01;
   endfunction

   function automatic int level_of(input int p, input int c, input int th);
      if ((p == 0 && c == 2) || (p == 2 && c == 0)) return 0;
      if (p == 0 || c == 0) return -th;
      return th;
   endfunction

   task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {early,late} actual=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic m, input int p, input int c,
                       input int e, input logic we, input int wd, input string req);
      logic [1:0] exp;
      @(negedge clk);
      sym_valid = v;
      mode_tri  = m;
      prev_dec  = 2'(p);
      curr_dec  = 2'(c);
      edge_smp  = EW'(e);
      thr_we    = we;
      thr_wdata = TW'(wd);
      @(posedge clk);
      #1;
      exp = v ? expect_vote(m, p, c, e, thr_m) : 2'b00;
      check(req, {early, late}, exp);
      if (!(early && late)) begin end else check("R3", {early, late}, 2'b00);
      if (we) thr_m = wd;
      sym_valid = 1'b0;
      thr_we    = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL R2: watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 outputs after reset", {early, late}, 2'b00);

      // R1: default threshold 32 seen through a -0.5 -> 0 transition
      step(1, 1, 0, 1, -32, 0, 0, "R1 default th at level");
      step(1, 1, 0, 1, -31, 0, 0, "R1 default th above");

      // R4 / R5 two-level table, zero edge resolves to -1
      for (int p = 0; p < 2; p++)
         for (int c = 0; c < 2; c++)
            for (int k = 0; k < 3; k++)
               step(1, 0, p + 2, c, (k - 1) * 5, 0, 0, (p == c) ? "R4" : "R5");

      // R7 R8 R9: every transition, one below / at / one above its level
      for (int p = 0; p < 3; p++)
         for (int c = 0; c < 3; c++)
            if (p != c)
               for (int d = -1; d <= 1; d++)
                  step(1, 1, p, c, level_of(p, c, thr_m) + d, 0, 0,
                       (c > p) ? "R7 R8" : "R7 R9");

      // R6: equal codes and the unused code
      step(1, 1, 1, 1, 100, 0, 0, "R6 equal");
      step(1, 1, 3, 0, -100, 0, 0, "R6 bad prev");
      step(1, 1, 2, 3, 100, 0, 0, "R6 bad curr");

      // R2: no strobe, no output
      step(0, 1, 0, 2, 100, 0, 0, "R2 idle tri");
      step(0, 0, 0, 1, 50, 0, 0, "R2 idle bin");

      // R10: write coincident with a symbol uses the old threshold
      step(1, 1, 0, 1, -10, 1, 10, "R10 same cycle");
      step(1, 1, 0, 1, -10, 0, 0, "R10 new th");
      step(1, 1, 1, 2, 10, 0, 0, "R10 new pos th");
      step(1, 1, 0, 0, 0, 1, 127, "R10 write max");
      step(1, 1, 1, 2, 127, 0, 0, "R8 at max th");
      step(1, 1, 1, 0, -128, 0, 0, "R9 min sample");
      step(1, 1, 0, 0, 0, 1, 0, "R10 write zero");
      step(1, 1, 0, 1, 0, 0, 0, "R8 zero th");
      step(1, 1, 2, 1, 0, 0, 0, "R9 zero th");

      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
              int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 255)) - 128,
              $urandom_range(0, 15) == 0, int'($urandom_range(0, 127)),
              "R3/random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule